// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block sits between the processor and the clock tree and decides which clock groups run. The processor raises a one-cycle sleep request (a light one or a deep one). The block then moves among three power modes. In Run every clock group is on. In Wait only the core clock is gated and the system clock keeps running so that peripherals and wake logic stay alive. In Stop the core clock, the system clock, the peripheral clocks and the PLL output clock are all gated. The clock gate cells themselves are outside the block, which drives only their enables. An enabled, pending interrupt (a level input) or the reset input brings the block back to Run.

A small word-wide register port holds the software controls. These are two bits that permit or forbid each kind of sleep request, one bit that picks a deep Stop, and a mask with one clock enable per peripheral. A forbidden request acts as a no-op. A deep Stop also powers down the oscillator and the PLL for the lowest power, at the cost of a slower restart. On exit from a deep Stop the block first waits for an oscillator-ready input and then for a PLL-lock input. Only after that does it turn clocks back on. Clock groups are switched off one per cycle, starting with the core and ending with the peripherals, and they come back on in the opposite order.

Top module: `pmc_top`

## Requirements
- R1: After reset, and after any reset asserted in the middle of a sequence, every clock enable is 1, both power-down outputs are 0 and the mode output is 00. The control word at address 0 reads 0x0003: bit 0 permits Wait, bit 1 permits Stop and bit 2 selects deep Stop. The gate mask at address 1 reads all ones.
- R2: A Wait request in Run with bit 0 set clears core_clk_en at the next edge, while sys, PLL and peripheral enables stay on and the mode becomes 01.
- R3: A permitted Stop request in Run gates the clocks one group per edge. The core is cleared at edge 1 and the mode becomes 10 at that edge. The system clock is cleared at edge 2. The peripheral enables and pll_clk_en are cleared at edge 3.
- R4: While in Stop, pll_pwr_dn and osc_pwr_dn are 1 only if bit 2 was 1 when Stop was entered. In a shallow Stop they stay 0.
- R5: A Wait request with bit 0 clear, or a Stop request with bit 1 clear, leaves every output unchanged and the mode stays at 00.
- R6: A high irq_wake in Wait sets core_clk_en again at the next edge and the mode returns to 00.
- R7: A high irq_wake in a shallow Stop restores the clocks in reverse order. The peripheral enables and pll_clk_en come back at edge 1, the system clock at edge 2, and the core together with mode 00 at edge 3.
- R8: A high irq_wake in a deep Stop clears osc_pwr_dn at the next edge. pll_pwr_dn is cleared at the edge after osc_ready is seen high. All clocks stay off until pll_locked is seen high, and then the R7 sequence follows.
- R9: In Run and Wait, periph_clk_en bit i equals bit i of the gate mask. In Stop all peripheral enables are 0.
- R10: When both requests arrive in the same cycle, Stop wins if it is permitted. Otherwise Wait is taken if it is permitted.
- R11: A request made in Run while irq_wake is high is dropped, and the block stays in Run.
- R12: Address 2 reads the mode in bits 1:0 with the encoding Run=00, Wait=01, Stop=10. Writes to address 2 have no effect.
- R13: Requests that arrive outside Run are ignored. The block stays in its current mode until a wake occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_req | input | 1 | One-cycle light sleep request |
| stop_req | input | 1 | One-cycle deep sleep request |
| irq_wake | input | 1 | Level: an enabled interrupt is pending |
| osc_ready | input | 1 | Oscillator is stable |
| pll_locked | input | 1 | PLL has locked |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| core_clk_en | output | 1 | Core clock gate enable |
| sys_clk_en | output | 1 | System clock gate enable |
| pll_clk_en | output | 1 | PLL output clock gate enable |
| periph_clk_en | output | 16 | Per-peripheral clock gate enables |
| pll_pwr_dn | output | 1 | PLL power-down |
| osc_pwr_dn | output | 1 | Oscillator power-down |
| pm_mode | output | 2 | Current power mode |

## Verification
Two events can land in the same cycle. The first is a Wait request and a Stop request together. The bench raises both on the same clock under two control words. With Stop permitted, it expects mode 10 after one edge and the system clock gone after two. With only Wait permitted, it expects mode 01 and a system clock that stays on. The second is a request that arrives while irq_wake is already high. The bench raises both together and expects every enable to stay on and the mode to remain 00 after the edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_WAIT,
        ST_GATE_CORE,
        ST_GATE_SYS,
        ST_STOP,
        ST_OSC_UP,
        ST_PLL_UP,
        ST_UNGATE_PER,
        ST_UNGATE_SYS
    } pm_state_e;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_STOP = 2'b10
    } pm_mode_e;

    typedef struct packed {
        logic core;
        logic sys;
        logic per;
        logic pllclk;
        logic pll_pd;
        logic osc_pd;
    } clk_ctl_t;

    function automatic pm_mode_e mode_of(pm_state_e st);
        case (st)
            ST_RUN:  return MODE_RUN;
            ST_WAIT: return MODE_WAIT;
            default: return MODE_STOP;
        endcase
    endfunction

    function automatic clk_ctl_t ctl_of(pm_state_e st, logic deep);
        clk_ctl_t c;
        c = '{core: 1'b1, sys: 1'b1, per: 1'b1, pllclk: 1'b1,
              pll_pd: 1'b0, osc_pd: 1'b0};
        case (st)
            ST_WAIT:       c.core = 1'b0;
            ST_GATE_CORE:  c.core = 1'b0;
            ST_GATE_SYS: begin
                c.core = 1'b0;
                c.sys  = 1'b0;
            end
            ST_STOP: begin
                c = '{core: 1'b0, sys: 1'b0, per: 1'b0, pllclk: 1'b0,
                      pll_pd: deep, osc_pd: deep};
            end
            ST_OSC_UP: begin
                c = '{core: 1'b0, sys: 1'b0, per: 1'b0, pllclk: 1'b0,
                      pll_pd: 1'b1, osc_pd: 1'b0};
            end
            ST_PLL_UP: begin
                c = '{core: 1'b0, sys: 1'b0, per: 1'b0, pllclk: 1'b0,
                      pll_pd: 1'b0, osc_pd: 1'b0};
            end
            ST_UNGATE_PER: begin
                c.core = 1'b0;
                c.sys  = 1'b0;
            end
            ST_UNGATE_SYS: c.core = 1'b0;
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pmc_regs.sv
module pmc_regs #(
    parameter int DW   = 16,
    parameter int AW   = 2,
    parameter int NPER = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [1:0]      mode,
    output logic [DW-1:0]   rdata,
    output logic            wait_allow,
    output logic            stop_allow,
    output logic            deep_sel,
    output logic [NPER-1:0] pgate
);
    localparam logic [AW-1:0] A_CTRL = AW'(0);
    localparam logic [AW-1:0] A_GATE = AW'(1);
    localparam logic [AW-1:0] A_STAT = AW'(2);

    typedef struct packed {
        logic            wa;
        logic            sa;
        logic            deep;
        logic [NPER-1:0] gate;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            if (addr == A_CTRL) begin
                regs_d.wa   = wdata[0];
                regs_d.sa   = wdata[1];
                regs_d.deep = wdata[2];
            end
            if (addr == A_GATE) begin
                regs_d.gate = wdata[NPER-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.wa   <= 1'b1;
            regs_q.sa   <= 1'b1;
            regs_q.deep <= 1'b0;
            regs_q.gate <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: rdata[2:0] = {regs_q.deep, regs_q.sa, regs_q.wa};
            A_GATE: rdata[NPER-1:0] = regs_q.gate;
            A_STAT: rdata[1:0] = mode;
            default: rdata = '0;
        endcase
    end

    assign wait_allow = regs_q.wa;
    assign stop_allow = regs_q.sa;
    assign deep_sel   = regs_q.deep;
    assign pgate      = regs_q.gate;

    p_mode_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
    import pmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wait_req,
    input  logic     stop_req,
    input  logic     wake,
    input  logic     osc_ready,
    input  logic     pll_locked,
    input  logic     wait_allow,
    input  logic     stop_allow,
    input  logic     deep_sel,
    output clk_ctl_t ctl,
    output pm_mode_e mode
);
    typedef struct packed {
        pm_state_e st;
        logic      deep;
        clk_ctl_t  ctl;
        pm_mode_e  mode;
    } seq_t;

    seq_t seq_d, seq_q;
    pm_state_e nxt;

    always_comb begin
        seq_d = seq_q;
        nxt   = seq_q.st;
        case (seq_q.st)
            ST_RUN: begin
                if (!wake) begin
                    if (stop_req && stop_allow) begin
                        nxt        = ST_GATE_CORE;
                        seq_d.deep = deep_sel;
                    end else if (wait_req && wait_allow) begin
                        nxt = ST_WAIT;
                    end
                end
            end
            ST_WAIT:       if (wake) nxt = ST_RUN;
            ST_GATE_CORE:  nxt = ST_GATE_SYS;
            ST_GATE_SYS:   nxt = ST_STOP;
            ST_STOP: begin
                if (wake) nxt = seq_q.deep ? ST_OSC_UP : ST_UNGATE_PER;
            end
            ST_OSC_UP:     if (osc_ready)  nxt = ST_PLL_UP;
            ST_PLL_UP:     if (pll_locked) nxt = ST_UNGATE_PER;
            ST_UNGATE_PER: nxt = ST_UNGATE_SYS;
            ST_UNGATE_SYS: nxt = ST_RUN;
            default:       nxt = ST_RUN;
        endcase
        seq_d.st   = nxt;
        seq_d.ctl  = ctl_of(nxt, seq_d.deep);
        seq_d.mode = mode_of(nxt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_RUN;
            seq_q.deep <= 1'b0;
            seq_q.ctl  <= ctl_of(ST_RUN, 1'b0);
            seq_q.mode <= MODE_RUN;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ctl  = seq_q.ctl;
    assign mode = seq_q.mode;

    p_core_before_sys_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.ctl.sys) |-> !seq_q.ctl.core);

    p_per_after_sys_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.ctl.per) |-> !seq_q.ctl.sys);

    p_core_last_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.ctl.core) |-> (seq_q.ctl.sys && seq_q.ctl.per));

    p_pd_clocks_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ctl.pll_pd || seq_q.ctl.osc_pd) |-> (!seq_q.ctl.per && !seq_q.ctl.pllclk));

    p_pll_after_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.ctl.pll_pd) |-> ($past(osc_ready) && !seq_q.ctl.osc_pd));

    p_wait_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.mode == MODE_WAIT && !wake) |=> (seq_q.mode == MODE_WAIT));

endmodule

// File: rtl/pmc_gate.sv
module pmc_gate #(
    parameter int NPER = 16
) (
    input  logic            per_on,
    input  logic [NPER-1:0] pgate,
    output logic [NPER-1:0] en
);
    for (genvar i = 0; i < NPER; i++) begin : g_per
        assign en[i] = per_on & pgate[i];
    end
endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 2,
    parameter int NPER = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wait_req,
    input  logic            stop_req,
    input  logic            irq_wake,
    input  logic            osc_ready,
    input  logic            pll_locked,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            core_clk_en,
    output logic            sys_clk_en,
    output logic            pll_clk_en,
    output logic [NPER-1:0] periph_clk_en,
    output logic            pll_pwr_dn,
    output logic            osc_pwr_dn,
    output logic [1:0]      pm_mode
);
    logic            wait_allow, stop_allow, deep_sel;
    logic [NPER-1:0] pgate;
    clk_ctl_t        ctl;
    pm_mode_e        mode;

    pmc_regs #(.DW(DW), .AW(AW), .NPER(NPER)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .mode       (mode),
        .rdata      (reg_rdata),
        .wait_allow (wait_allow),
        .stop_allow (stop_allow),
        .deep_sel   (deep_sel),
        .pgate      (pgate)
    );

    pmc_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wait_req   (wait_req),
        .stop_req   (stop_req),
        .wake       (irq_wake),
        .osc_ready  (osc_ready),
        .pll_locked (pll_locked),
        .wait_allow (wait_allow),
        .stop_allow (stop_allow),
        .deep_sel   (deep_sel),
        .ctl        (ctl),
        .mode       (mode)
    );

    pmc_gate #(.NPER(NPER)) u_gate (
        .per_on (ctl.per),
        .pgate  (pgate),
        .en     (periph_clk_en)
    );

    assign core_clk_en = ctl.core;
    assign sys_clk_en  = ctl.sys;
    assign pll_clk_en  = ctl.pllclk;
    assign pll_pwr_dn  = ctl.pll_pd;
    assign osc_pwr_dn  = ctl.osc_pd;
    assign pm_mode     = mode;

endmodule

// File: tb/tb_pmc_top.sv
module tb_pmc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wait_req = 1'b0, stop_req = 1'b0, irq_wake = 1'b0;
    logic        osc_ready = 1'b0, pll_locked = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        core_clk_en, sys_clk_en, pll_clk_en, pll_pwr_dn, osc_pwr_dn;
    logic [15:0] periph_clk_en;
    logic [1:0]  pm_mode;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pmc_top dut (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
        .irq_wake(irq_wake), .osc_ready(osc_ready), .pll_locked(pll_locked),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en),
        .pll_clk_en(pll_clk_en), .periph_clk_en(periph_clk_en),
        .pll_pwr_dn(pll_pwr_dn), .osc_pwr_dn(osc_pwr_dn), .pm_mode(pm_mode)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // packed view: {core, sys, pllclk, pll_pd, osc_pd, mode[1:0], periph[15:0]}
    task automatic chk_out(input string rq, input logic c, input logic s,
                           input logic p, input logic ppd, input logic opd,
                           input logic [1:0] m, input logic [15:0] per);
        chk(rq, "outputs",
            {9'd0, core_clk_en, sys_clk_en, pll_clk_en, pll_pwr_dn, osc_pwr_dn, pm_mode, periph_clk_en},
            {9'd0, c, s, p, ppd, opd, m, per});
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic w, input logic s);
        wait_req = w; stop_req = s;
        tick();
        wait_req = 1'b0; stop_req = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk_out("R1", 1, 1, 1, 0, 0, 2'b00, 16'hFFFF);
        rd_reg(2'd0, d); chk("R1", "ctrl reset", {16'd0, d}, 32'h3);
        rd_reg(2'd1, d); chk("R1", "mask reset", {16'd0, d}, 32'hFFFF);
    endtask

    task automatic t_wait();
        logic [15:0] d;
        wr_reg(2'd1, 16'hA5C3);
        chk_out("R9", 1, 1, 1, 0, 0, 2'b00, 16'hA5C3);
        pulse(1, 0);
        chk_out("R2", 0, 1, 1, 0, 0, 2'b01, 16'hA5C3);
        rd_reg(2'd2, d); chk("R12", "status wait", {16'd0, d}, 32'h1);
        pulse(0, 1);
        chk_out("R13", 0, 1, 1, 0, 0, 2'b01, 16'hA5C3);
        pulse(1, 0);
        chk_out("R13", 0, 1, 1, 0, 0, 2'b01, 16'hA5C3);
        irq_wake = 1'b1;
        tick();
        irq_wake = 1'b0;
        chk_out("R6", 1, 1, 1, 0, 0, 2'b00, 16'hA5C3);
    endtask

    task automatic t_stop_shallow();
        logic [15:0] d;
        wr_reg(2'd0, 16'h0003);
        pulse(0, 1);
        chk_out("R3", 0, 1, 1, 0, 0, 2'b10, 16'hA5C3);
        tick();
        chk_out("R3", 0, 0, 1, 0, 0, 2'b10, 16'hA5C3);
        tick();
        chk_out("R3", 0, 0, 0, 0, 0, 2'b10, 16'h0000);
        rd_reg(2'd2, d); chk("R12", "status stop", {16'd0, d}, 32'h2);
        pulse(1, 1);
        tick();
        chk_out("R4", 0, 0, 0, 0, 0, 2'b10, 16'h0000);
        irq_wake = 1'b1;
        tick();
        irq_wake = 1'b0;
        chk_out("R7", 0, 0, 1, 0, 0, 2'b10, 16'hA5C3);
        tick();
        chk_out("R7", 0, 1, 1, 0, 0, 2'b10, 16'hA5C3);
        tick();
        chk_out("R7", 1, 1, 1, 0, 0, 2'b00, 16'hA5C3);
    endtask

    task automatic t_stop_deep();
        wr_reg(2'd1, 16'hFFFF);
        wr_reg(2'd0, 16'h0007);
        pulse(0, 1);
        tick(); tick();
        chk_out("R4", 0, 0, 0, 1, 1, 2'b10, 16'h0000);
        irq_wake = 1'b1;
        tick();
        irq_wake = 1'b0;
        chk_out("R8", 0, 0, 0, 1, 0, 2'b10, 16'h0000);
        repeat (3) tick();
        chk_out("R8", 0, 0, 0, 1, 0, 2'b10, 16'h0000);
        osc_ready = 1'b1;
        tick();
        chk_out("R8", 0, 0, 0, 0, 0, 2'b10, 16'h0000);
        repeat (2) tick();
        chk_out("R8", 0, 0, 0, 0, 0, 2'b10, 16'h0000);
        pll_locked = 1'b1;
        tick();
        chk_out("R8", 0, 0, 1, 0, 0, 2'b10, 16'hFFFF);
        tick();
        chk_out("R8", 0, 1, 1, 0, 0, 2'b10, 16'hFFFF);
        tick();
        chk_out("R8", 1, 1, 1, 0, 0, 2'b00, 16'hFFFF);
        osc_ready = 1'b0; pll_locked = 1'b0;
    endtask

    task automatic t_disabled();
        wr_reg(2'd0, 16'h0004);
        pulse(1, 0);
        chk_out("R5", 1, 1, 1, 0, 0, 2'b00, 16'hFFFF);
        pulse(0, 1);
        chk_out("R5", 1, 1, 1, 0, 0, 2'b00, 16'hFFFF);
        tick();
        chk_out("R5", 1, 1, 1, 0, 0, 2'b00, 16'hFFFF);
    endtask

    task automatic t_both();
        wr_reg(2'd0, 16'h0003);
        pulse(1, 1);
        chk_out("R10", 0, 1, 1, 0, 0, 2'b10, 16'hFFFF);
        tick();
        chk_out("R10", 0, 0, 1, 0, 0, 2'b10, 16'hFFFF);
        tick();
        irq_wake = 1'b1;
        repeat (4) tick();
        irq_wake = 1'b0;
        chk_out("R10", 1, 1, 1, 0, 0, 2'b00, 16'hFFFF);
        wr_reg(2'd0, 16'h0001);
        pulse(1, 1);
        chk_out("R10", 0, 1, 1, 0, 0, 2'b01, 16'hFFFF);
        tick();
        chk_out("R10", 0, 1, 1, 0, 0, 2'b01, 16'hFFFF);
        irq_wake = 1'b1;
        tick();
        irq_wake = 1'b0;
    endtask

    task automatic t_wake_pending();
        wr_reg(2'd0, 16'h0003);
        irq_wake = 1'b1;
        pulse(0, 1);
        chk_out("R11", 1, 1, 1, 0, 0, 2'b00, 16'hFFFF);
        pulse(1, 0);
        chk_out("R11", 1, 1, 1, 0, 0, 2'b00, 16'hFFFF);
        irq_wake = 1'b0;
    endtask

    task automatic t_status_ro();
        logic [15:0] d;
        wr_reg(2'd2, 16'h0003);
        rd_reg(2'd2, d); chk("R12", "status ro", {16'd0, d}, 32'h0);
        chk_out("R12", 1, 1, 1, 0, 0, 2'b00, 16'hFFFF);
    endtask

    task automatic t_mid_reset();
        logic [15:0] d;
        wr_reg(2'd0, 16'h0007);
        wr_reg(2'd1, 16'h00F0);
        pulse(0, 1);
        tick(); tick();
        do_reset();
        chk_out("R1", 1, 1, 1, 0, 0, 2'b00, 16'hFFFF);
        rd_reg(2'd0, d); chk("R1", "ctrl after reset", {16'd0, d}, 32'h3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick();
        do_reset();
        t_reset();
        t_wait();
        t_stop_shallow();
        t_stop_deep();
        t_disabled();
        t_both();
        t_wake_pending();
        t_status_ro();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule